// File: doc/BRIEF.md
# Burst Bus Master with Port Sizing

This block is the requesting side of a synchronous external bus that moves whole aligned blocks of 16 or 32 bytes. A requester hands it one block transfer, read or write, together with a start address. An on-chip chip-select decoder supplies three things at that moment: the width of the addressed slave port, whether the decoder itself will return the transfer acknowledge, and that acknowledge's wait-state count. The block raises a one-cycle start strobe with the address and a burst indicator. It then steps through the block in beats as wide as the slave port, wrapping the address inside the aligned block.

The slave can refuse to burst. It does so by raising burst-inhibit with the acknowledge of the first beat. The block then fetches or stores every remaining beat of the block with its own single-beat cycle, each with its own start strobe. During a burst a continue signal tells the slave whether another beat follows the current one. That signal has a normal timing and a late timing. In late timing its first assertion waits out the first beat's wait states. The bus stays locked from the first strobe to the last acknowledge, so nothing else can use the bus in the middle of a transaction. Read data is collected into a block-wide buffer, and a one-cycle done pulse reports completion.

Top module: `burst_port_master`

## Requirements
- R1: After synchronous reset the block is idle: `req_ready` is 1, and `bus_ts`, `bus_lock`, `bus_bdip` and `done` are 0.
- R2: A request accepted while `req_ready` is 1 gives `bus_ts` high for exactly the next cycle. In that cycle `bus_burst` is 1 and `bus_addr` holds the first beat's address. `bus_ts` is never high in two consecutive cycles.
- R3: `cs_port` selects the beat width: 2'b00 for 32 bits, 2'b01 for 8 bits, 2'b10 for 16 bits, and 2'b11 is treated as 32 bits. A 16-byte block takes 4, 8 or 16 beats on a 32-, 16- or 8-bit port. A 32-byte block takes twice as many. `cs_port`, `cs_int_ack`, `cs_waits` and `req_late` are sampled only when a request is accepted.
- R4: The low two bits of `req_addr` are ignored. Beat i is at offset (start offset + i × beat bytes) modulo the block size, within the aligned block. `bus_addr` changes only after an acknowledge.
- R5: In a write, each beat's bytes sit on the low lanes of `bus_wdata`, least significant byte first. Byte k of `req_wline` is block byte k. Unused lanes are 0, and the next beat appears in the cycle after each acknowledge.
- R6: In a read, the active low lanes of `bus_rdata` are stored into `rd_line` at the beat's block offset on each acknowledge, and higher lanes are dropped. `done` pulses for one cycle, in the cycle after the final acknowledge.
- R7: If `bus_bi` is 1 with the first acknowledge of a burst, every remaining beat is carried by its own cycle. Each such cycle has its own one-cycle `bus_ts` with `bus_burst` 0 and `bus_bdip` 0. There are 3, 7 or 15 single cycles for a 16-byte block on a 32-, 16- or 8-bit port.
- R8: `bus_bi` on any acknowledge other than the first beat of a burst has no effect.
- R9: In normal timing, `bus_bdip` is 1 in every data-phase cycle of a burst beat that is not the last, and 0 during the last beat.
- R10: In late timing, `bus_bdip` stays 0 for the first `cs_waits` data-phase cycles of the first beat and then behaves as in normal timing. With zero waits it is identical to normal timing.
- R11: Late timing applies only when `req_late` and `cs_int_ack` are both 1 at acceptance. Otherwise normal timing is used.
- R12: `bus_lock` is 1 from the start strobe through the cycle of the final acknowledge, including all single-beat cycles. `req_ready` is 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Block transfer request |
| req_ready | output | 1 | Idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write block, 0 = read block |
| req_long | input | 1 | 1 = 32-byte block, 0 = 16-byte block |
| req_late | input | 1 | Ask for late timing of the continue signal |
| req_addr | input | ADDR_W | Start address (word granular) |
| req_wline | input | 256 | Write block, byte k = block byte k |
| cs_port | input | 2 | Port width code from the chip-select decoder |
| cs_int_ack | input | 1 | Decoder generates the acknowledge itself |
| cs_waits | input | WAIT_W | Wait states of the decoder-generated acknowledge |
| bus_ts | output | 1 | Start strobe |
| bus_addr | output | ADDR_W | Beat address |
| bus_burst | output | 1 | Burst indicator |
| bus_write | output | 1 | Transfer direction on the bus |
| bus_bdip | output | 1 | Another beat follows the current one |
| bus_lock | output | 1 | Bus held for the transaction |
| bus_wdata | output | 32 | Write beat data, low lanes |
| bus_rdata | input | 32 | Read beat data, low lanes |
| bus_ta | input | 1 | Transfer acknowledge |
| bus_bi | input | 1 | Burst inhibit, meaningful with the first acknowledge |
| done | output | 1 | One-cycle completion pulse |
| rd_line | output | 256 | Collected read block |

## Verification
The properties assume that the slave raises `bus_ta` only in data-phase cycles, never in the strobe cycle or while idle. They also assume that late timing is paired with a decoder whose first acknowledge really comes after the programmed `cs_waits` cycles. The bench's slave model therefore drives the acknowledge only after each strobe cycle has passed. Whenever late timing is in effect, it sets the first-beat wait count equal to `cs_waits`. It chooses all other waits, burst-inhibit on later beats, unused data lanes and unaligned low address bits at random from a fixed seed.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    localparam int BUS_BYTES = 4;
    localparam int LINE_MAX  = 32;
    localparam int LINE_BITS = LINE_MAX * 8;
    localparam int OFF_W     = $clog2(LINE_MAX);
    localparam int BEAT_W    = OFF_W + 1;

    typedef enum logic [1:0] {
        PORT_W32 = 2'b00,
        PORT_W8  = 2'b01,
        PORT_W16 = 2'b10,
        PORT_RSV = 2'b11
    } port_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic       write;
        logic       long_line;
        logic       late;
        logic [1:0] lane_shift;   // log2 of bytes per beat
    } xfer_cfg_t;

    function automatic logic [1:0] lane_shift_of(input logic [1:0] code);
        case (port_code_e'(code))
            PORT_W8:  return 2'd0;
            PORT_W16: return 2'd1;
            default:  return 2'd2;
        endcase
    endfunction

    function automatic logic [BEAT_W-1:0] beats_of(input logic [1:0] shift,
                                                   input logic       long_line);
        logic [BEAT_W-1:0] bytes;
        bytes = long_line ? BEAT_W'(LINE_MAX) : BEAT_W'(LINE_MAX / 2);
        return bytes >> shift;
    endfunction

endpackage

// File: rtl/bpm_seq.sv
module bpm_seq
    import bpm_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_long,
    input  logic              req_late,
    input  logic [1:0]        cs_port,
    input  logic              cs_int_ack,
    input  logic [WAIT_W-1:0] cs_waits,
    input  logic              bus_ta,
    input  logic              bus_bi,
    output logic              req_ready,
    output logic              start,
    output logic              ack,
    output logic              bus_ts,
    output logic              bus_burst,
    output logic              bus_write,
    output logic              bus_bdip,
    output logic              bus_lock,
    output logic              done,
    output logic [BEAT_W-1:0] beat_idx,
    output xfer_cfg_t         cfg
);

    seq_state_e        state_q;
    xfer_cfg_t         cfg_q;
    logic [WAIT_W-1:0] waits_q;
    logic [WAIT_W-1:0] wcyc_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] nbeats;
    logic              single_q;
    logic              last_beat;
    logic              late_ok;

    assign nbeats    = beats_of(cfg_q.lane_shift, cfg_q.long_line);
    assign last_beat = (beat_q == nbeats - BEAT_W'(1));
    assign start     = (state_q == ST_IDLE) && req_valid;
    assign ack       = (state_q == ST_DATA) && bus_ta;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cfg_q    <= '0;
            waits_q  <= '0;
            wcyc_q   <= '0;
            beat_q   <= '0;
            single_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cfg_q <= '{write:      req_write,
                                   long_line:  req_long,
                                   late:       req_late & cs_int_ack,
                                   lane_shift: lane_shift_of(cs_port)};
                        waits_q  <= cs_waits;
                        beat_q   <= '0;
                        single_q <= 1'b0;
                        state_q  <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    wcyc_q  <= '0;
                    state_q <= ST_DATA;
                end
                ST_DATA: begin
                    if (bus_ta) begin
                        beat_q <= beat_q + BEAT_W'(1);
                        if (last_beat) begin
                            state_q <= ST_DONE;
                        end else if (single_q) begin
                            state_q <= ST_ADDR;
                        end else if ((beat_q == '0) && bus_bi) begin
                            single_q <= 1'b1;
                            state_q  <= ST_ADDR;
                        end
                    end else if (wcyc_q != '1) begin
                        wcyc_q <= wcyc_q + WAIT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // late timing holds off the continue signal during the first beat's waits
    assign late_ok   = !cfg_q.late || (beat_q != '0) || (wcyc_q >= waits_q);

    assign req_ready = (state_q == ST_IDLE);
    assign bus_ts    = (state_q == ST_ADDR);
    assign bus_lock  = (state_q == ST_ADDR) || (state_q == ST_DATA);
    assign bus_burst = bus_lock && !single_q;
    assign bus_write = bus_lock && cfg_q.write;
    assign bus_bdip  = (state_q == ST_DATA) && !single_q && !last_beat && late_ok;
    assign done      = (state_q == ST_DONE);
    assign beat_idx  = beat_q;
    assign cfg       = cfg_q;

endmodule

// File: rtl/bpm_addr.sv
module bpm_addr
    import bpm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BEAT_W-1:0] beat_idx,
    input  logic [1:0]        lane_shift,
    input  logic              long_line,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [OFF_W-1:0]  line_off
);

    logic [ADDR_W-1:0] base_q;
    logic [OFF_W-1:0]  start_off;
    logic [OFF_W-1:0]  step;
    logic [OFF_W-1:0]  sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (start) begin
            base_q <= req_addr;
        end
    end

    assign start_off = base_q[OFF_W-1:0] & ~OFF_W'(3);
    assign step      = OFF_W'(beat_idx) << lane_shift;
    assign sum       = start_off + step;

    always_comb begin
        if (long_line) begin
            line_off = sum;
            bus_addr = {base_q[ADDR_W-1:OFF_W], sum};
        end else begin
            line_off = {1'b0, sum[OFF_W-2:0]};
            bus_addr = {base_q[ADDR_W-1:OFF_W-1], sum[OFF_W-2:0]};
        end
    end

endmodule

// File: rtl/bpm_data.sv
module bpm_data
    import bpm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [LINE_BITS-1:0] req_wline,
    input  logic                 ack,
    input  logic                 wr_active,
    input  logic                 is_write,
    input  logic [1:0]           lane_shift,
    input  logic [OFF_W-1:0]     line_off,
    input  logic [31:0]          bus_rdata,
    output logic [31:0]          bus_wdata,
    output logic [LINE_BITS-1:0] rd_line
);

    logic [7:0] wbuf_q [LINE_MAX];
    logic [7:0] rbuf_q [LINE_MAX];
    logic [2:0] lanes;

    assign lanes = 3'd1 << lane_shift;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LINE_MAX; k++) begin
                wbuf_q[k] <= '0;
                rbuf_q[k] <= '0;
            end
        end else begin
            if (start) begin
                for (int k = 0; k < LINE_MAX; k++) begin
                    wbuf_q[k] <= req_wline[8*k +: 8];
                end
            end
            if (ack && !is_write) begin
                for (int j = 0; j < BUS_BYTES; j++) begin
                    if (3'(j) < lanes) begin
                        rbuf_q[line_off + OFF_W'(j)] <= bus_rdata[8*j +: 8];
                    end
                end
            end
        end
    end

    always_comb begin
        bus_wdata = '0;
        if (wr_active) begin
            for (int j = 0; j < BUS_BYTES; j++) begin
                if (3'(j) < lanes) begin
                    bus_wdata[8*j +: 8] = wbuf_q[line_off + OFF_W'(j)];
                end
            end
        end
    end

    for (genvar k = 0; k < LINE_MAX; k++) begin : g_rd
        assign rd_line[8*k +: 8] = rbuf_q[k];
    end

endmodule

// File: rtl/burst_port_master.sv
module burst_port_master
    import bpm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_long,
    input  logic              req_late,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [255:0]      req_wline,
    input  logic [1:0]        cs_port,
    input  logic              cs_int_ack,
    input  logic [WAIT_W-1:0] cs_waits,
    output logic              bus_ts,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_burst,
    output logic              bus_write,
    output logic              bus_bdip,
    output logic              bus_lock,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ta,
    input  logic              bus_bi,
    output logic              done,
    output logic [255:0]      rd_line
);

    logic              start;
    logic              ack;
    logic [BEAT_W-1:0] beat_idx;
    xfer_cfg_t         cfg;
    logic [OFF_W-1:0]  line_off;

    bpm_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_long   (req_long),
        .req_late   (req_late),
        .cs_port    (cs_port),
        .cs_int_ack (cs_int_ack),
        .cs_waits   (cs_waits),
        .bus_ta     (bus_ta),
        .bus_bi     (bus_bi),
        .req_ready  (req_ready),
        .start      (start),
        .ack        (ack),
        .bus_ts     (bus_ts),
        .bus_burst  (bus_burst),
        .bus_write  (bus_write),
        .bus_bdip   (bus_bdip),
        .bus_lock   (bus_lock),
        .done       (done),
        .beat_idx   (beat_idx),
        .cfg        (cfg)
    );

    bpm_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req_addr   (req_addr),
        .beat_idx   (beat_idx),
        .lane_shift (cfg.lane_shift),
        .long_line  (cfg.long_line),
        .bus_addr   (bus_addr),
        .line_off   (line_off)
    );

    bpm_data u_data (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req_wline  (req_wline),
        .ack        (ack),
        .wr_active  (bus_write),
        .is_write   (cfg.write),
        .lane_shift (cfg.lane_shift),
        .line_off   (line_off),
        .bus_rdata  (bus_rdata),
        .bus_wdata  (bus_wdata),
        .rd_line    (rd_line)
    );

endmodule

// File: rtl/burst_port_master_chk.sv
module burst_port_master_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              bus_ts,
    input logic              bus_burst,
    input logic              bus_bdip,
    input logic              bus_lock,
    input logic              bus_ta,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr
);

    p_ts_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        bus_ts |=> !bus_ts);

    p_ts_locked_r12: assert property (@(posedge clk) disable iff (rst)
        bus_ts |-> bus_lock);

    p_ready_unlocked_r12: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!bus_lock && !bus_ts));

    p_bdip_data_phase_r9: assert property (@(posedge clk) disable iff (rst)
        bus_bdip |-> (bus_lock && !bus_ts));

    p_single_no_bdip_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_ts && !bus_burst) |=> !bus_bdip);

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_lock && $past(bus_lock) && !$past(bus_ta)) |-> $stable(bus_addr));

    p_done_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!bus_lock && $past(bus_lock) && $past(bus_ta)));

endmodule

bind burst_port_master burst_port_master_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_burst_port_master.sv
module tb_burst_port_master;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int WAIT_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic              req_long = 1'b0;
    logic              req_late = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [255:0]      req_wline = '0;
    logic [1:0]        cs_port = 2'b00;
    logic              cs_int_ack = 1'b0;
    logic [WAIT_W-1:0] cs_waits = '0;
    logic              bus_ts, bus_burst, bus_write, bus_bdip, bus_lock, done;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata = '0;
    logic              bus_ta = 1'b0;
    logic              bus_bi = 1'b0;
    logic [255:0]      rd_line;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_port_master #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_long(req_long), .req_late(req_late),
        .req_addr(req_addr), .req_wline(req_wline), .cs_port(cs_port),
        .cs_int_ack(cs_int_ack), .cs_waits(cs_waits), .bus_ts(bus_ts),
        .bus_addr(bus_addr), .bus_burst(bus_burst), .bus_write(bus_write),
        .bus_bdip(bus_bdip), .bus_lock(bus_lock), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ta(bus_ta), .bus_bi(bus_bi),
        .done(done), .rd_line(rd_line)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lanes_of(input logic [1:0] code);
        if (code == 2'b01) return 1;
        if (code == 2'b10) return 2;
        return 4;
    endfunction

    function automatic int exp_off(input logic [31:0] a, input int i,
                                   input int lanes, input int lb);
        return ((int'(a[4:0]) & ~3) + i * lanes) % lb;
    endfunction

    // one block transfer, called and returning at a falling edge
    task automatic run_xfer(input bit wr, input bit lng, input bit late,
                            input bit intack, input int waits,
                            input logic [1:0] code, input logic [31:0] addr,
                            input bit bi_first, input bit bi_later, input int w0);
        logic [255:0] wl;
        logic [7:0]   mem [32];
        int lanes, lb, n, off, w;
        bit late_eff, single, eb;
        logic [31:0] ea, ew, rd;
        for (int k = 0; k < 8; k++) wl[32*k +: 32] = $urandom;
        for (int k = 0; k < 32; k++) mem[k] = 8'h00;
        lanes    = lanes_of(code);
        lb       = lng ? 32 : 16;
        n        = lb / lanes;
        late_eff = late && intack;
        single   = 0;

        req_valid = 1; req_write = wr; req_long = lng; req_late = late;
        req_addr = addr; req_wline = wl; cs_port = code; cs_int_ack = intack;
        cs_waits = WAIT_W'(waits);
        chk(req_ready == 1'b1, "R12 ready before request", 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        // R3/R11: decoder inputs change after acceptance and must be ignored
        req_valid = 0; cs_port = code ^ 2'b11; cs_int_ack = ~intack;
        req_late = ~late; cs_waits = WAIT_W'($urandom_range(0, 15));

        for (int i = 0; i < n; i++) begin
            off = exp_off(addr, i, lanes, lb);
            ea  = (addr & ~32'(lb - 1)) | 32'(off);
            if (i == 0 || single) begin
                chk(bus_ts == 1'b1, "R2 strobe", 64'(bus_ts), 64'd1);
                chk(bus_burst == !single, "R7 burst indicator", 64'(bus_burst), 64'(!single));
                chk(bus_addr == ea, "R4 strobe address", 64'(bus_addr), 64'(ea));
                chk(bus_lock == 1'b1, "R12 lock at strobe", 64'(bus_lock), 64'd1);
                @(negedge clk);
            end
            w = (i == 0) ? w0 : $urandom_range(0, 2);
            for (int c = 0; c <= w; c++) begin
                eb = !single && (i != n - 1) && (i != 0 || !late_eff || c >= waits);
                chk(bus_ts == 1'b0, "R2 strobe low in data", 64'(bus_ts), 64'd0);
                chk(bus_addr == ea, "R4 beat address", 64'(bus_addr), 64'(ea));
                chk(bus_bdip == eb, late_eff ? "R10 late continue" : "R9 continue",
                    64'(bus_bdip), 64'(eb));
                chk(bus_lock == 1'b1 && done == 1'b0, "R12 lock in data",
                    64'({bus_lock, done}), 64'b10);
                if (wr) begin
                    ew = '0;
                    for (int j = 0; j < lanes; j++) ew[8*j +: 8] = wl[8*(off + j) +: 8];
                    chk(bus_wdata == ew, "R5 write beat", 64'(bus_wdata), 64'(ew));
                end
                if (c == w) begin
                    rd = $urandom;
                    bus_rdata = rd;
                    bus_ta = 1;
                    bus_bi = (i == 0) ? bi_first : bi_later;
                    if (!wr) for (int j = 0; j < lanes; j++) mem[off + j] = rd[8*j +: 8];
                end
                @(negedge clk);
                bus_ta = 0; bus_bi = 0;
            end
            if (i == 0 && bi_first) single = 1;
        end
        chk(done == 1'b1, "R6 done pulse", 64'(done), 64'd1);
        chk(bus_lock == 1'b0, "R12 lock released", 64'(bus_lock), 64'd0);
        if (!wr) begin
            for (int k = 0; k < lb; k++)
                chk(rd_line[8*k +: 8] == mem[k], "R6 read block byte",
                    64'(rd_line[8*k +: 8]), 64'(mem[k]));
        end
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", 64'(done), 64'd0);
        chk(req_ready == 1'b1, "R12 ready after", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;
        chk(req_ready == 1'b1 && bus_ts == 1'b0 && bus_lock == 1'b0 &&
            bus_bdip == 1'b0 && done == 1'b0, "R1 reset state",
            64'({req_ready, bus_ts, bus_lock, bus_bdip, done}), 64'b10000);
        @(negedge clk);

        // directed corners: wr lng late intack waits code addr bi_first bi_later w0
        run_xfer(0, 0, 0, 0, 0, 2'b00, 32'h1000_0008, 0, 0, 0); // R3 R4 wrap
        run_xfer(1, 0, 0, 0, 0, 2'b01, 32'h2000_0004, 0, 0, 1); // R5 8-bit
        run_xfer(0, 1, 0, 0, 0, 2'b10, 32'h3000_001E, 0, 0, 2); // R4 low bits ignored
        run_xfer(1, 1, 0, 0, 0, 2'b00, 32'h4000_0010, 0, 0, 0);
        run_xfer(0, 0, 0, 0, 0, 2'b01, 32'h5000_000C, 1, 0, 1); // R7 15 singles
        run_xfer(1, 0, 0, 0, 0, 2'b00, 32'h6000_0004, 1, 0, 0); // R7 3 singles
        run_xfer(0, 0, 0, 0, 0, 2'b10, 32'h7000_0000, 0, 1, 0); // R8 late BI ignored
        run_xfer(0, 0, 1, 1, 3, 2'b10, 32'h8000_0004, 0, 0, 3); // R10 late
        run_xfer(1, 0, 1, 1, 0, 2'b00, 32'h8100_0008, 0, 0, 0); // R10 zero waits
        run_xfer(0, 0, 1, 0, 3, 2'b00, 32'h8200_0000, 0, 0, 3); // R11 no internal ack
        run_xfer(1, 1, 0, 0, 0, 2'b11, 32'h9000_0014, 0, 0, 1); // R3 reserved code

        for (int t = 0; t < 40; t++) begin
            bit wr, lng, late, ia, bf, bl;
            int wt, w0;
            logic [1:0] code;
            wr = 1'($urandom); lng = 1'($urandom); late = 1'($urandom);
            ia = 1'($urandom); code = 2'($urandom);
            wt = $urandom_range(0, 3);
            bf = ($urandom_range(0, 3) == 0);
            bl = ($urandom_range(0, 2) == 0);
            w0 = (late && ia) ? wt : $urandom_range(0, 3);
            run_xfer(wr, lng, late, ia, wt, code, $urandom, bf, bl, w0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule